// File: doc/BRIEF.md
# Vector register and predicate redirection table

This block sits beside the issue stage of a core that turns ordinary scalar instructions into parallel ones by retagging their register operands. Software writes a small set of keyed configuration entries. There are sixteen entries that describe registers and sixteen that describe predicates. The block expands these entries into two flat lookup tables, each indexed by register type (integer or floating point) and register number.

When the issue stage presents a register number and a type, the block answers combinationally with four results:
- whether that register is treated as a vector;
- which physical register it is redirected to;
- its element width code and its packed-SIMD flag;
- the effective predicate mask and zeroing flag.

The mask always comes from the integer register file. The block drives the integer register index it needs to read and receives that register's value back. When no predicate entry applies, the mask is all ones.

Each configuration write restarts a sequential rebuild. The rebuild first clears both tables in the write cycle. It then folds in one register entry and one predicate entry per cycle, in ascending entry order. While the rebuild runs, `busy` is high, and the issue stage must hold off lookups until it drops.

Top module: `vecreg_remap`

## Requirements
- R1: After reset `busy` is 0 and every lookup reports no vector (`lk_isvec`=0, `lk_idx` = the looked-up register number, `lk_ew`=0, `lk_pk`=0), with `lk_pred` all ones, `lk_zero`=0 and `mrd_idx`=0.
- R2: A configuration write at a clock edge raises `busy` from the next cycle for exactly NENT cycles. A further write while `busy` is high restarts the count. `busy` never rises without a write.
- R3: A register entry (`cfg_sel`=0) uses this layout: bit 16 valid, bit 15 bank, bit 14 packed, bit 13 vector, bits 12:11 element width, bits 10:6 target, bits 5:1 key, bit 0 type (0 integer, 1 FP). A lookup with the same type and key returns the entry's element width and packed flag. Integer and FP tables are separate.
- R4: For a register whose entry has the vector bit set, `lk_idx` = target + 32·bank. Otherwise `lk_idx` is the looked-up register number with bit 5 clear.
- R5: An entry written with its valid bit at 0 contributes nothing to either table.
- R6: When two valid entries of the same kind share key and type, the higher-numbered entry decides the lookup result.
- R7: A predicate entry (`cfg_sel`=1) uses this layout: bit 16 valid, bit 13 bank, bit 12 zeroing, bit 11 invert, bits 10:6 mask register, bits 5:1 key, bit 0 type. For a matching lookup, `mrd_idx` = mask register + 32·bank and `lk_zero` = the zeroing bit. `lk_pred` is `mrd_data`, or its bitwise inverse when the invert bit is set.
- R8: With no valid predicate entry for the looked-up type and register, `lk_pred` is all ones, `lk_zero` is 0 and `mrd_idx` is 0.
- R9: FP lookups take their mask from the same integer read port as integer lookups.
- R10: Rewriting an entry replaces its earlier contribution entirely: the tables are rebuilt from the current entries only.
- R11: Different keys may redirect to the same target register, and each lookup reports its own entry's attributes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects a register entry, 1 a predicate entry |
| cfg_addr | input | $clog2(NENT) | Entry number |
| cfg_data | input | 17 | Entry contents |
| busy | output | 1 | Rebuild in progress; lookups must wait |
| lk_fp | input | 1 | Lookup type: 0 integer, 1 FP |
| lk_reg | input | 5 | Register number from the instruction |
| lk_isvec | output | 1 | Register is treated as a vector |
| lk_idx | output | 6 | Redirected register index |
| lk_ew | output | 2 | Element width code |
| lk_pk | output | 1 | Packed-SIMD flag |
| mrd_idx | output | 6 | Integer register to read for the mask |
| mrd_data | input | XLEN | Value of that integer register |
| lk_pred | output | XLEN | Effective predicate mask |
| lk_zero | output | 1 | Non-predicated elements are zeroed |

## Verification
Some properties hold on every cycle, and the assertions check them:
- the rebuild window is exactly NENT cycles after the last write;
- `busy` only rises after a write;
- a non-vector answer always carries the register's own number;
- the mask is always `mrd_data`, its inverse, or all ones.

Other behaviour depends on which entries were written, so only the bench's configured scenarios can show it. This covers the field layouts, the bank offset, the higher entry winning on a shared key, invalid entries having no effect, overlapping targets, FP lookups using the integer mask port, and the removal of a mapping by a rewrite.

// File: rtl/vecreg_remap.sv
module vecreg_remap #(
  parameter int XLEN = 32,
  parameter int NENT = 16,
  localparam int AW = $clog2(NENT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [16:0]     cfg_data,
  output logic            busy,
  input  logic            lk_fp,
  input  logic [4:0]      lk_reg,
  output logic            lk_isvec,
  output logic [5:0]      lk_idx,
  output logic [1:0]      lk_ew,
  output logic            lk_pk,
  output logic [5:0]      mrd_idx,
  input  logic [XLEN-1:0] mrd_data,
  output logic [XLEN-1:0] lk_pred,
  output logic            lk_zero
);

  localparam int TSZ = 64;

  logic [16:0]   rcfg [NENT];
  logic [14:0]   pcfg [NENT];
  logic [10:0]   rtab [TSZ];
  logic [8:0]    ptab [TSZ];
  logic [AW-1:0] cnt;
  logic [16:0]   rc;
  logic [14:0]   pc;
  logic [10:0]   re;
  logic [8:0]    pe;

  assign rc = rcfg[cnt];
  assign pc = pcfg[cnt];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      for (int i = 0; i < NENT; i++) begin
        rcfg[i] <= '0;
        pcfg[i] <= '0;
      end
      for (int i = 0; i < TSZ; i++) begin
        rtab[i] <= '0;
        ptab[i] <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_sel) pcfg[cfg_addr] <= {cfg_data[16], cfg_data[13:0]};
      else         rcfg[cfg_addr] <= cfg_data;
      for (int i = 0; i < TSZ; i++) begin
        rtab[i] <= '0;
        ptab[i] <= '0;
      end
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (rc[16]) rtab[{rc[0], rc[5:1]}] <= {1'b1, rc[15:6]};
      if (pc[14]) ptab[{pc[0], pc[5:1]}] <= {1'b1, pc[13:6]};
      if (cnt == AW'(NENT - 1)) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  assign re = rtab[{lk_fp, lk_reg}];
  assign pe = ptab[{lk_fp, lk_reg}];

  assign lk_isvec = re[10] & re[7];
  assign lk_idx   = lk_isvec ? {re[9], re[4:0]} : {1'b0, lk_reg};
  assign lk_ew    = re[10] ? re[6:5] : 2'd0;
  assign lk_pk    = re[10] & re[8];

  assign mrd_idx  = pe[8] ? {pe[7], pe[4:0]} : 6'd0;
  assign lk_pred  = !pe[8] ? {XLEN{1'b1}} : (pe[5] ? ~mrd_data : mrd_data);
  assign lk_zero  = pe[8] & pe[6];

endmodule

module vecreg_remap_chk #(
  parameter int XLEN = 32,
  parameter int NENT = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic            busy,
  input logic [4:0]      lk_reg,
  input logic            lk_isvec,
  input logic [5:0]      lk_idx,
  input logic [XLEN-1:0] mrd_data,
  input logic [XLEN-1:0] lk_pred
);
  localparam int CW = $clog2(NENT + 1);
  logic [CW-1:0] cyc;

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_we) cyc <= '0;
    else if (busy) cyc <= cyc + 1'b1;
  end

  // R2
  busy_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> busy);

  // R2
  idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg_we) |=> !busy);

  // R2
  rebuild_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cyc == CW'(NENT));

  // R4
  scalar_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_isvec |-> lk_idx == {1'b0, lk_reg});

  // R7
  pred_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_pred == mrd_data) || (lk_pred == ~mrd_data) || (&lk_pred));
endmodule

bind vecreg_remap vecreg_remap_chk #(.XLEN(XLEN), .NENT(NENT)) u_chk (.*);

// File: tb/vecreg_remap_bench.sv
module vecreg_remap_bench;
  localparam int XLEN = 32;
  localparam int NENT = 16;
  localparam int AW = $clog2(NENT);

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [16:0] cfg_data = '0;
  logic busy, lk_fp = 0;
  logic [4:0] lk_reg = '0;
  logic lk_isvec, lk_pk, lk_zero;
  logic [5:0] lk_idx, mrd_idx;
  logic [1:0] lk_ew;
  logic [XLEN-1:0] mrd_data, lk_pred;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;
  assign mrd_data = 32'hC3A0_0000 | {26'd0, mrd_idx};

  vecreg_remap #(.XLEN(XLEN), .NENT(NENT)) u_vecreg_remap (.*);

  function automatic logic [16:0] renc(input logic v, t, input logic [4:0] k, tg,
                                       input logic [1:0] ew, input logic vec, pk, bk);
    return {v, bk, pk, vec, ew, tg, k, t};
  endfunction
  function automatic logic [16:0] penc(input logic v, t, input logic [4:0] k, mr,
                                       input logic inv, zr, bk);
    return {v, 2'b00, bk, zr, inv, mr, k, t};
  endfunction

  task automatic wr(input logic sel, input int a, input logic [16:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_addr = AW'(a); cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic settle;
    while (busy) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [42:0] act, exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic look(input logic fp, input logic [4:0] r, input string req,
                      input logic [42:0] exp_v);
    @(negedge clk);
    lk_fp = fp; lk_reg = r;
    #1;
    chk(req, {lk_isvec, lk_idx, lk_ew, lk_pk, lk_pred, lk_zero}, exp_v);
  endtask

  // {fp, reg, isvec, idx, ew, pk, pred, zero}
  localparam logic [48:0] TBL [8] = '{
    {1'b0, 5'd3,  1'b1, 6'd10, 2'd2, 1'b0, 32'hC3A00005, 1'b1},
    {1'b1, 5'd3,  1'b1, 6'd25, 2'd3, 1'b0, 32'h3C5FFFF9, 1'b0},
    {1'b0, 5'd7,  1'b1, 6'd10, 2'd3, 1'b1, 32'hFFFFFFFF, 1'b0},
    {1'b0, 5'd9,  1'b0, 6'd9,  2'd0, 1'b0, 32'hFFFFFFFF, 1'b0},
    {1'b0, 5'd12, 1'b1, 6'd33, 2'd0, 1'b0, 32'hC3A00022, 1'b0},
    {1'b1, 5'd7,  1'b0, 6'd7,  2'd0, 1'b0, 32'hFFFFFFFF, 1'b0},
    {1'b1, 5'd12, 1'b0, 6'd12, 2'd0, 1'b0, 32'hFFFFFFFF, 1'b0},
    {1'b0, 5'd0,  1'b0, 6'd0,  2'd0, 1'b0, 32'hFFFFFFFF, 1'b0}
  };

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 busy", {42'd0, busy}, 43'd0);
    look(0, 5'd3, "R1 int lookup", {1'b1 ^ 1'b1, 6'd3, 2'd0, 1'b0, 32'hFFFFFFFF, 1'b0});
    look(1, 5'd17, "R1 fp lookup", {1'b0, 6'd17, 2'd0, 1'b0, 32'hFFFFFFFF, 1'b0});
    chk("R8 mrd_idx after reset", {37'd0, mrd_idx}, 43'd0);

    // R2: busy window length
    wr(0, 0, renc(1, 0, 5'd3, 5'd10, 2'd2, 1, 0, 0));
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk("R2 busy length", 43'(n), 43'(NENT));

    wr(0, 1, renc(1, 1, 5'd3, 5'd20, 2'd1, 1, 1, 0));
    wr(0, 2, renc(1, 0, 5'd7, 5'd10, 2'd3, 1, 1, 0));   // R11 overlap target
    wr(0, 3, renc(1, 0, 5'd9, 5'd4, 2'd0, 0, 0, 0));
    wr(0, 4, renc(0, 0, 5'd3, 5'd31, 2'd1, 1, 1, 0));   // R5 invalid
    wr(0, 5, renc(1, 0, 5'd12, 5'd1, 2'd0, 1, 0, 1));   // R4 bank
    wr(0, 9, renc(1, 1, 5'd3, 5'd25, 2'd3, 1, 0, 0));   // R6 wins over 1
    wr(1, 0, penc(1, 0, 5'd3, 5'd5, 0, 1, 0));
    wr(1, 1, penc(1, 1, 5'd3, 5'd6, 1, 0, 0));          // R9 fp via int port
    wr(1, 2, penc(1, 0, 5'd12, 5'd2, 0, 0, 1));
    wr(1, 3, penc(0, 0, 5'd9, 5'd8, 1, 1, 0));          // R5 invalid
    chk("R2 busy after write", {42'd0, busy}, 43'd1);
    settle();

    for (int i = 0; i < 8; i++)
      look(TBL[i][48], TBL[i][47:43], $sformatf("R3/R4/R5/R6/R7/R8/R9/R11 row %0d", i),
           TBL[i][42:0]);

    // R10: invalidate entries and check rebuilt state
    wr(0, 0, renc(0, 0, 5'd3, 5'd10, 2'd2, 1, 0, 0));
    wr(0, 9, renc(0, 1, 5'd3, 5'd25, 2'd3, 1, 0, 0));
    settle();
    look(0, 5'd3, "R10 int 3 removed", {1'b0, 6'd3, 2'd0, 1'b0, 32'hC3A00005, 1'b1});
    look(1, 5'd3, "R10 R6 fp 3 falls back to entry 1",
         {1'b1, 6'd20, 2'd1, 1'b1, 32'h3C5FFFF9, 1'b0});
    look(0, 5'd7, "R11 int 7 kept", {1'b1, 6'd10, 2'd3, 1'b1, 32'hFFFFFFFF, 1'b0});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule